// File: doc/BRIEF.md
# Serial Clock Prescaler Search Engine

This block chooses a divider setting for a serial interface clock. It receives the frequency of the clock to be divided and a wanted serial bit rate. It then searches every divisor of the form `k << e`, where k is a linear factor and e is a power-of-two exponent. The result is the setting that gives the highest achievable rate that does not exceed the wanted rate. The chosen pair is presented already packed into the bit positions of an 8-bit configuration field, so a controller can load it unchanged.

A one-cycle `start` pulse captures both frequencies and begins the search. Each candidate rate is produced by an internal restoring divider that yields one quotient bit per clock. The search stops at once when a candidate hits the target exactly. When the search ends, `done` pulses for one cycle. `err` then reports whether a usable setting was found. The result outputs hold their values until the next start.

Top module: `presc_search`

## Requirements
- R1: After reset `busy`, `done` and `err` are 0, and `lin_out`, `exp_out` and `cfg_out` are 0.
- R2: A `start` pulse while idle samples `clk_hz` and `rate_hz`. Later changes of these inputs have no effect on the result. `busy` is 1 from the cycle after start until `done` rises, and `done` is 1 for exactly one cycle with `busy` low.
- R3: Candidates are visited with the linear factor k from 1 to LIN_MAX in the outer loop and the exponent e from 0 to EXP_MAX in the inner loop. A candidate whose rate exceeds the target is rejected. Any other candidate replaces the held best only if its shortfall (target minus rate) is strictly smaller than the best shortfall so far, which starts at all ones. When candidates tie, the first one visited is kept.
- R4: A candidate whose rate equals the target is chosen at once and the search ends without visiting later candidates.
- R5: If no candidate is accepted, `err` is 1 at `done`, and `lin_out`, `exp_out` and `cfg_out` are 0.
- R6: If `rate_hz` equals `clk_hz` at start, `err` is reported with `done` on the next cycle, no search is run, and `busy` stays 0.
- R7: `cfg_out[3:0]` holds the linear factor, `cfg_out[4]` holds exponent bit 0, `cfg_out[7:6]` hold exponent bits 2:1, and `cfg_out[5]` is 0.
- R8: A candidate rate is `clk_hz / (k << e)` with the fraction truncated. Each candidate costs W+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a search |
| clk_hz | input | W | Frequency of the clock to be divided |
| rate_hz | input | W | Wanted serial bit rate |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No usable setting, or target equal to input clock |
| lin_out | output | 4 | Chosen linear factor |
| exp_out | output | 3 | Chosen exponent |
| cfg_out | output | 8 | Chosen pair packed into configuration bit positions |

## Verification
The bench builds the block with its defaults: W = 32, LIN_MAX = 15 and EXP_MAX = 7. These values open the full 120-candidate space with 32-bit frequencies, so realistic clock and bit rates can be used. They also make reachable an exact hit in the top exponent, a three-way tie among equal divisors, a full search that finds nothing, and the exit taken when the target equals the clock. The exact-hit and full-search cases also bound the length of the busy window, which shows whether the search stopped early.

// File: rtl/presc_search.sv
module presc_search #(
  parameter int W       = 32,
  parameter int LIN_MAX = 15,
  parameter int EXP_MAX = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] clk_hz,
  input  logic [W-1:0] rate_hz,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [3:0]   lin_out,
  output logic [2:0]   exp_out,
  output logic [7:0]   cfg_out
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);
  localparam logic [3:0] LIN_TOP = 4'(LIN_MAX);
  localparam logic [2:0] EXP_TOP = 3'(EXP_MAX);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_EVAL} state_t;

  state_t        st;
  logic [W-1:0]  clk_q, rate_q, dvd, rem, best_diff;
  logic [CW-1:0] cnt;
  logic [3:0]    lin, best_lin;
  logic [2:0]    ex, best_ex;
  logic          err_q, done_q;

  logic [W-1:0]  dsr, diff;
  logic [W:0]    rem_sh;
  logic          sub_ok, exact, better, take, last_cand;

  assign dsr       = W'(lin) << ex;
  assign rem_sh    = {rem, dvd[W-1]};
  assign sub_ok    = rem_sh >= {1'b0, dsr};
  assign diff      = rate_q - dvd;
  assign exact     = dvd == rate_q;
  assign better    = (dvd < rate_q) && (diff < best_diff);
  assign take      = exact || better;
  assign last_cand = (lin == LIN_TOP) && (ex == EXP_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      clk_q     <= '0;
      rate_q    <= '0;
      dvd       <= '0;
      rem       <= '0;
      best_diff <= '1;
      cnt       <= '0;
      lin       <= '0;
      ex        <= '0;
      best_lin  <= '0;
      best_ex   <= '0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          clk_q     <= clk_hz;
          rate_q    <= rate_hz;
          best_lin  <= '0;
          best_ex   <= '0;
          best_diff <= '1;
          err_q     <= 1'b0;
          if (clk_hz == rate_hz) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
          end else begin
            lin <= 4'd1;
            ex  <= '0;
            rem <= '0;
            dvd <= clk_hz;
            cnt <= '0;
            st  <= S_DIV;
          end
        end
        S_DIV: begin
          rem <= sub_ok ? W'(rem_sh - {1'b0, dsr}) : rem_sh[W-1:0];
          dvd <= {dvd[W-2:0], sub_ok};
          cnt <= cnt + 1'b1;
          if (cnt == LAST_BIT) st <= S_EVAL;
        end
        S_EVAL: begin
          if (take) begin
            best_lin  <= lin;
            best_ex   <= ex;
            best_diff <= diff;
          end
          if (exact || last_cand) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            err_q  <= !take && (best_lin == '0);
          end else begin
            if (ex == EXP_TOP) begin
              ex  <= '0;
              lin <= lin + 1'b1;
            end else begin
              ex <= ex + 1'b1;
            end
            rem <= '0;
            dvd <= clk_q;
            cnt <= '0;
            st  <= S_DIV;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = st != S_IDLE;
  assign done    = done_q;
  assign err     = err_q;
  assign lin_out = best_lin;
  assign exp_out = best_ex;
  assign cfg_out = {best_ex[2:1], 1'b0, best_ex[0], best_lin};

  logic [2*W-1:0] prod;
  assign prod = {{W{1'b0}}, dvd} * {{W{1'b0}}, dsr};

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (lin_out == '0 && cfg_out == '0));
  assert_quot_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EVAL) |-> (prod <= {{W{1'b0}}, clk_q}));
  assert_quot_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EVAL) |-> ((prod + {{W{1'b0}}, dsr}) > {{W{1'b0}}, clk_q}));
  assert_ok_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (lin_out != '0));
endmodule

// File: tb/presc_search_tb.sv
module presc_search_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] clk_hz = '0, rate_hz = '0;
  logic         busy, done, err;
  logic [3:0]   lin_out;
  logic [2:0]   exp_out;
  logic [7:0]   cfg_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  presc_search #(.W(W), .LIN_MAX(15), .EXP_MAX(7)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_hz(clk_hz), .rate_hz(rate_hz),
    .busy(busy), .done(done), .err(err), .lin_out(lin_out), .exp_out(exp_out),
    .cfg_out(cfg_out)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ref_search(input logic [W-1:0] c, input logic [W-1:0] r,
                            output logic [3:0] l, output logic [2:0] e, output bit er);
    logic [W-1:0] bd, q;
    bit hit;
    bd = '1; l = 0; e = 0; hit = 0;
    if (c == r) begin er = 1; return; end
    for (int k = 1; k <= 15 && !hit; k++) begin
      for (int x = 0; x <= 7; x++) begin
        q = c / (W'(k) << x);
        if (q > r) continue;
        if (q == r) begin l = 4'(k); e = 3'(x); hit = 1; break; end
        if ((r - q) < bd) begin bd = r - q; l = 4'(k); e = 3'(x); end
      end
    end
    er = (l == 0);
  endtask

  // Runs one search; returns the busy window length and first-cycle busy flag.
  task automatic run(input logic [W-1:0] c, input logic [W-1:0] r,
                     output int cycles, output bit busy0);
    @(negedge clk);
    clk_hz = c; rate_hz = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy0 = busy;
    cycles = 1;
    while (!done && cycles < 6000) begin
      @(negedge clk);
      cycles++;
    end
    chk(done == 1'b1, "R2 done reached", done, 1);
  endtask

  task automatic check_after(input string req, input logic [3:0] l, input logic [2:0] e, input bit er);
    chk(err == er, {req, " err"}, err, er);
    chk(lin_out == l && exp_out == e, {req, " pair"}, {lin_out, exp_out}, {l, e});
    chk(cfg_out == {e[2:1], 1'b0, e[0], l}, {req, " R7 packing"}, cfg_out, {e[2:1], 1'b0, e[0], l});
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R2 done one cycle", {done, busy}, 0);
  endtask

  task automatic t_reset;
    chk(busy == 0 && done == 0 && err == 0, "R1 flags", {busy, done, err}, 0);
    chk(lin_out == 0 && exp_out == 0 && cfg_out == 0, "R1 outputs", cfg_out, 0);
  endtask

  task automatic t_exact;
    int n; bit b0;
    run(250_000_000, 50_000_000, n, b0);
    chk(b0 == 1'b1, "R2 busy after start", b0, 1);
    chk(n <= 33 * (W + 1) + 3, "R4 early stop", n, 33 * (W + 1) + 3);
    check_after("R4 exact", 4'd5, 3'd0, 1'b0);
  endtask

  task automatic t_packing;
    int n; bit b0;
    run(1000, 1, n, b0);
    chk(cfg_out == 8'hD4, "R7 cfg top exponent", cfg_out, 8'hD4);
    check_after("R8 truncation", 4'd4, 3'd7, 1'b0);
  endtask

  task automatic t_tie;
    int n; bit b0;
    run(24, 7, n, b0);
    check_after("R3 first tie kept", 4'd1, 3'd2, 1'b0);
  endtask

  task automatic t_range;
    int n; bit b0;
    run(100_000, 10, n, b0);
    chk(n >= 120 * (W + 1), "R3 full sweep length", n, 120 * (W + 1));
    check_after("R5 out of range", 4'd0, 3'd0, 1'b1);
  endtask

  task automatic t_equal;
    int n; bit b0;
    run(1000, 1000, n, b0);
    chk(n == 1 && b0 == 1'b0, "R6 immediate error", n, 1);
    check_after("R6 equal target", 4'd0, 3'd0, 1'b1);
  endtask

  task automatic t_sample;
    int n;
    @(negedge clk);
    clk_hz = 24; rate_hz = 7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    clk_hz = 250_000_000; rate_hz = 50_000_000;
    n = 0;
    while (!done && n < 6000) begin
      @(negedge clk);
      n++;
    end
    check_after("R2 inputs sampled", 4'd1, 3'd2, 1'b0);
  endtask

  task automatic t_sweep;
    logic [W-1:0] cs [5] = '{250_000_000, 250_000_000, 250_000_000, 200_000_000, 1_000_000};
    logic [W-1:0] rs [5] = '{32'd20971520, 32'h0080_0000, 32'h0020_0000, 3_000_000, 999};
    foreach (cs[i]) begin
      logic [3:0] l; logic [2:0] e; bit er; int n; bit b0;
      ref_search(cs[i], rs[i], l, e, er);
      run(cs[i], rs[i], n, b0);
      check_after("R3 sweep", l, e, er);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_exact();
    t_packing();
    t_tie();
    t_range();
    t_equal();
    t_sample();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule